// File: doc/BRIEF.md
# Multiplexed Analog-Input Conversion Sequencer

This block runs one analog-input conversion per host command. A host start command carries a multiplexer point address, a point type (relay or solid-state) and, for relay points, a request to wait for an external sync pulse. The sequencer latches the address and flags it busy, passes a fixed interlock stage, then drives one X line and one Y line that select the point. At the same moment it clears the address-busy flag and advances the address register by one. It then times a start settling delay, starts the converter, waits for end-of-convert, resets the drivers, times an end settling delay and raises a service request.

There are two kinds of start command. A direct-program write sets a completion flag when the conversion finishes. A data-channel start raises a cycle-steal request instead. Both the completion flag and the cycle-steal request stay high until the host strobes sense-with-reset. A direct-program write also sets a relay-busy or solid-state-busy flag. That flag holds until the host issues a read or blast-reset command.

Commands that conflict with work already in progress are dropped without any error indication. While a relay point is selected, a write to the converter-resolution setting has no effect. All delays are counted in clock cycles and set by parameters. With the `FAST_ADC` variant, the solid-state drivers reset when the converter starts and the solid-state end delay is skipped.

Top module: `adcseq_top`

## Requirements
- R1: After reset, every driver line, busy flag, request, strobe and sync output is low and `adc_res` is 0.
- R2: A start command is accepted when the sequencer is idle. On the next cycle `addr_busy` is 1 and `pt_addr` equals the commanded address.
- R3: Three cycles after acceptance, the drivers turn on. `x_drv` is one-hot at bit `addr[XB-1:0]` and `y_drv` is one-hot at bit `addr[AW-1:XB]`. In the same cycle `addr_busy` returns to 0 and `pt_addr` becomes address+1, wrapping modulo 2^AW. `relay_drv` is 1 for relay points and `ss_drv` is 1 for solid-state points.
- R4: `adc_start` is a one-cycle pulse. For a solid-state point it comes SS_SD cycles after the drivers turn on. For a relay point without sync it comes RLY_SD+BSW_CYC cycles after the drivers turn on.
- R5: Relay drivers go low in the cycle after end-of-convert is sampled. With FAST_ADC, solid-state drivers are already low in the cycle where `adc_start` is high.
- R6: For a relay point, the service request appears RLY_ED cycles after end-of-convert is sampled. With FAST_ADC, a solid-state point requests service in the cycle immediately after end-of-convert.
- R7: Completion of a direct-program write sets `conv_done`. Completion of a data-channel start sets `cs_req`. Either one clears one cycle after `sense_rst`.
- R8: Several commands are dropped without effect, so `addr_busy` stays 0 and `pt_addr` is unchanged:
  - any start command that arrives while a sequence is running;
  - a write while `cs_req` or `ss_busy` is 1;
  - a data-channel start while `ss_busy` is 1.
- R9: A direct-program write sets `relay_busy` (relay point) or `ss_busy` (solid-state point). The flag holds, even through `sense_rst`, until `cmd_read` clears it.
- R10: For a relay point with sync requested, `sync_ready` rises RLY_SD+BSW_CYC cycles after the drivers turn on. `adc_start` follows in the cycle after `sync_start` is sampled.
- R11: `sync_late` rises if `sync_start` has not arrived within SYNC_TO cycles of `sync_ready` rising. It clears when the next command is accepted.
- R12: `res_wr` loads `res_val` into `adc_res` on the next cycle, except while `relay_drv` is 1, when the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Direct-program start strobe |
| cmd_init | input | 1 | Data-channel start strobe |
| cmd_addr | input | AW | Point address for a start command |
| cmd_relay | input | 1 | 1 = relay point, 0 = solid-state point |
| cmd_xsync | input | 1 | Wait for external sync (relay points only) |
| cmd_read | input | 1 | Read / blast-reset; clears relay_busy and ss_busy |
| sense_rst | input | 1 | Acknowledge; clears conv_done and cs_req |
| res_wr | input | 1 | Resolution write strobe |
| res_val | input | RW | Resolution value |
| adc_eoc | input | 1 | Converter end-of-convert |
| sync_start | input | 1 | External sync-start pulse |
| pt_addr | output | AW | Point address register |
| addr_busy | output | 1 | Address loaded, drivers not yet set |
| x_drv | output | 2^XB | One-hot X select lines |
| y_drv | output | 2^(AW-XB) | One-hot Y select lines |
| relay_drv | output | 1 | Relay point drivers active |
| ss_drv | output | 1 | Solid-state point drivers active |
| adc_start | output | 1 | Converter start pulse |
| sync_ready | output | 1 | Waiting for external sync |
| sync_late | output | 1 | External sync arrived too late |
| conv_done | output | 1 | Direct-program completion flag |
| cs_req | output | 1 | Cycle-steal request |
| relay_busy | output | 1 | Relay direct-program operation outstanding |
| ss_busy | output | 1 | Solid-state direct-program operation outstanding |
| adc_res | output | RW | Converter resolution setting |

## Verification
A wrong sequencer state shows up quickly at the ports. It moves the cycle where the drivers turn on or `adc_start` pulses, so a timing count taken from the previous visible event is off by at least one. A wrong timer load shifts `adc_start`, `sync_ready` or the service request by a fixed number of cycles within a single operation. Flag errors stay hidden until the next command. A stuck or missing busy flag only appears when a later start command is wrongly taken or wrongly dropped, so every operation is followed by deliberate blocked-command probes.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE  = 4'd0,
    S_LOAD  = 4'd1,
    S_LOCK  = 4'd2,
    S_DRV   = 4'd3,
    S_SDLY  = 4'd4,
    S_BSW   = 4'd5,
    S_SYNC  = 4'd6,
    S_START = 4'd7,
    S_WEOC  = 4'd8,
    S_EDLY  = 4'd9
  } seq_st_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcseq_oneshot.sv
module adcseq_oneshot #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)               cnt_n = load_val;
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/adcseq_ptreg.sv
module adcseq_ptreg #(
  parameter int AW = 6,
  parameter int XB = 3,
  localparam int YB = AW - XB,
  localparam int XN = 1 << XB,
  localparam int YN = 1 << YB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          drv_set,
  input  logic          drv_clr,
  output logic [AW-1:0] pt_addr,
  output logic          busy,
  output logic          drv_on,
  output logic [XN-1:0] x_drv,
  output logic [YN-1:0] y_drv
);

  logic [AW-1:0] addr_q, addr_n;
  logic          busy_q, busy_n;
  logic          on_q, on_n;
  logic [XB-1:0] xi_q, xi_n;
  logic [YB-1:0] yi_q, yi_n;

  always_comb begin
    addr_n = addr_q;
    busy_n = busy_q;
    on_n   = on_q;
    xi_n   = xi_q;
    yi_n   = yi_q;
    if (load) begin
      addr_n = load_addr;
      busy_n = 1'b1;
    end else if (drv_set) begin
      xi_n   = addr_q[XB-1:0];
      yi_n   = addr_q[AW-1:XB];
      on_n   = 1'b1;
      busy_n = 1'b0;
      addr_n = addr_q + AW'(1);
    end
    if (drv_clr) on_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      busy_q <= 1'b0;
      on_q   <= 1'b0;
      xi_q   <= '0;
      yi_q   <= '0;
    end else begin
      addr_q <= addr_n;
      busy_q <= busy_n;
      on_q   <= on_n;
      xi_q   <= xi_n;
      yi_q   <= yi_n;
    end
  end

  for (genvar i = 0; i < XN; i++) begin : g_xdec
    assign x_drv[i] = on_q && (xi_q == XB'(i));
  end
  for (genvar j = 0; j < YN; j++) begin : g_ydec
    assign y_drv[j] = on_q && (yi_q == YB'(j));
  end

  assign pt_addr = addr_q;
  assign busy    = busy_q;
  assign drv_on  = on_q;

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int AW       = 6,
  parameter int XB       = 3,
  parameter int RW       = 2,
  parameter int FAST_ADC = 1,
  parameter int RLY_SD   = 4000,
  parameter int BSW_CYC  = 18,
  parameter int RLY_ED   = 3000,
  parameter int SS_SD    = 20,
  parameter int SS_ED    = 10,
  parameter int SYNC_TO  = 330000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_wr,
  input  logic                    cmd_init,
  input  logic [AW-1:0]           cmd_addr,
  input  logic                    cmd_relay,
  input  logic                    cmd_xsync,
  input  logic                    cmd_read,
  input  logic                    sense_rst,
  input  logic                    res_wr,
  input  logic [RW-1:0]           res_val,
  input  logic                    adc_eoc,
  input  logic                    sync_start,
  output logic [AW-1:0]           pt_addr,
  output logic                    addr_busy,
  output logic [(1<<XB)-1:0]      x_drv,
  output logic [(1<<(AW-XB))-1:0] y_drv,
  output logic                    relay_drv,
  output logic                    ss_drv,
  output logic                    adc_start,
  output logic                    sync_ready,
  output logic                    sync_late,
  output logic                    conv_done,
  output logic                    cs_req,
  output logic                    relay_busy,
  output logic                    ss_busy,
  output logic [RW-1:0]           adc_res
);

  localparam int MAXD = max2(max2(max2(RLY_SD, BSW_CYC), max2(RLY_ED, SS_SD)),
                             max2(SS_ED, SYNC_TO));
  localparam int TW   = $clog2(MAXD + 1);
  localparam bit FAST = (FAST_ADC != 0);
  localparam logic [TW-1:0] LD_RSD = TW'(RLY_SD - 1);
  localparam logic [TW-1:0] LD_BSW = TW'(BSW_CYC - 1);
  localparam logic [TW-1:0] LD_RED = TW'(RLY_ED - 1);
  localparam logic [TW-1:0] LD_SSD = TW'(SS_SD - 1);
  localparam logic [TW-1:0] LD_SED = TW'(SS_ED - 1);
  localparam logic [TW-1:0] LD_STO = TW'(SYNC_TO - 1);

  seq_st_e       st_q, st_n;
  logic          relay_q, xsync_q, chan_q;
  logic          acc_wr, acc_init, accept;
  logic          tmr_ld, tmr_exp;
  logic [TW-1:0] tmr_val;
  logic          drv_set, drv_clr, set_req, drv_on;
  logic          done_q, done_n, cs_q, cs_n;
  logic          rbusy_q, rbusy_n, sbusy_q, sbusy_n;
  logic          late_q, late_n;
  logic [RW-1:0] res_q, res_n;
  logic          kind_en;

  // command acceptance
  assign acc_wr   = (st_q == S_IDLE) && cmd_wr && !cs_q && !sbusy_q;
  assign acc_init = (st_q == S_IDLE) && cmd_init && !cmd_wr && !addr_busy && !sbusy_q;
  assign accept   = acc_wr || acc_init;

  // next-state logic
  always_comb begin
    st_n    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    drv_set = 1'b0;
    drv_clr = 1'b0;
    set_req = 1'b0;
    unique case (st_q)
      S_IDLE:  if (accept) st_n = S_LOAD;
      S_LOAD:  st_n = S_LOCK;
      S_LOCK:  st_n = S_DRV;
      S_DRV: begin
        drv_set = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = relay_q ? LD_RSD : LD_SSD;
        st_n    = S_SDLY;
      end
      S_SDLY: if (tmr_exp) begin
        if (relay_q) begin
          st_n    = S_BSW;
          tmr_ld  = 1'b1;
          tmr_val = LD_BSW;
        end else begin
          st_n    = S_START;
          drv_clr = FAST;
        end
      end
      S_BSW: if (tmr_exp) begin
        if (xsync_q) begin
          st_n    = S_SYNC;
          tmr_ld  = 1'b1;
          tmr_val = LD_STO;
        end else begin
          st_n = S_START;
        end
      end
      S_SYNC:  if (sync_start) st_n = S_START;
      S_START: st_n = S_WEOC;
      S_WEOC: if (adc_eoc) begin
        drv_clr = 1'b1;
        if (!relay_q && FAST) begin
          st_n    = S_IDLE;
          set_req = 1'b1;
        end else begin
          st_n    = S_EDLY;
          tmr_ld  = 1'b1;
          tmr_val = relay_q ? LD_RED : LD_SED;
        end
      end
      S_EDLY: if (tmr_exp) begin
        st_n    = S_IDLE;
        set_req = 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  // flag next values
  always_comb begin
    done_n  = done_q;
    cs_n    = cs_q;
    rbusy_n = rbusy_q;
    sbusy_n = sbusy_q;
    late_n  = late_q;
    res_n   = res_q;
    if (sense_rst) begin
      done_n = 1'b0;
      cs_n   = 1'b0;
    end
    if (set_req) begin
      if (chan_q) cs_n   = 1'b1;
      else        done_n = 1'b1;
    end
    if (cmd_read) begin
      rbusy_n = 1'b0;
      sbusy_n = 1'b0;
    end
    if (acc_wr) begin
      if (cmd_relay) rbusy_n = 1'b1;
      else           sbusy_n = 1'b1;
    end
    if (accept)
      late_n = 1'b0;
    else if ((st_q == S_SYNC) && tmr_exp && !sync_start)
      late_n = 1'b1;
    if (res_wr && !relay_drv)
      res_n = res_val;
  end

  assign kind_en = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      done_q  <= 1'b0;
      cs_q    <= 1'b0;
      rbusy_q <= 1'b0;
      sbusy_q <= 1'b0;
      late_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      st_q    <= st_n;
      done_q  <= done_n;
      cs_q    <= cs_n;
      rbusy_q <= rbusy_n;
      sbusy_q <= sbusy_n;
      late_q  <= late_n;
      res_q   <= res_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      relay_q <= 1'b0;
      xsync_q <= 1'b0;
      chan_q  <= 1'b0;
    end else if (kind_en) begin
      relay_q <= cmd_relay;
      xsync_q <= cmd_relay && cmd_xsync;
      chan_q  <= acc_init;
    end
  end

  adcseq_oneshot #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  adcseq_ptreg #(.AW(AW), .XB(XB)) u_pt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_addr (cmd_addr),
    .drv_set   (drv_set),
    .drv_clr   (drv_clr),
    .pt_addr   (pt_addr),
    .busy      (addr_busy),
    .drv_on    (drv_on),
    .x_drv     (x_drv),
    .y_drv     (y_drv)
  );

  assign relay_drv  = drv_on && relay_q;
  assign ss_drv     = drv_on && !relay_q;
  assign adc_start  = (st_q == S_START);
  assign sync_ready = (st_q == S_SYNC);
  assign sync_late  = late_q;
  assign conv_done  = done_q;
  assign cs_req     = cs_q;
  assign relay_busy = rbusy_q;
  assign ss_busy    = sbusy_q;
  assign adc_res    = res_q;

endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int XN = 8,
  parameter int YN = 8,
  parameter int RW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [XN-1:0] x_drv,
  input logic [YN-1:0] y_drv,
  input logic          relay_drv,
  input logic          ss_drv,
  input logic          adc_start,
  input logic          conv_done,
  input logic          res_wr,
  input logic [RW-1:0] adc_res,
  input logic          ss_busy,
  input logic          cmd_read
);

  // R3
  drv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(x_drv) && $onehot0(y_drv));

  // R3
  drv_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(relay_drv && ss_drv));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R7
  done_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_done) |-> (!relay_drv && !ss_drv));

  // R9
  ss_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_busy && !cmd_read) |=> ss_busy);

  // R12
  res_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (relay_drv && res_wr) |=> $stable(adc_res));

endmodule

bind adcseq_top adcseq_chk #(.XN(1 << XB), .YN(1 << (AW - XB)), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .x_drv     (x_drv),
  .y_drv     (y_drv),
  .relay_drv (relay_drv),
  .ss_drv    (ss_drv),
  .adc_start (adc_start),
  .conv_done (conv_done),
  .res_wr    (res_wr),
  .adc_res   (adc_res),
  .ss_busy   (ss_busy),
  .cmd_read  (cmd_read)
);

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;

  localparam int RSD = 12, BSW = 5, RED = 9, SSD = 4, SED = 3, STO = 40;

  logic       clk, rst_n;
  logic       cmd_wr, cmd_init, cmd_relay, cmd_xsync, cmd_read, sense_rst;
  logic [5:0] cmd_addr;
  logic       res_wr;
  logic [1:0] res_val;
  logic       adc_eoc, sync_start;
  logic [5:0] pt_addr;
  logic       addr_busy;
  logic [7:0] x_drv, y_drv;
  logic       relay_drv, ss_drv, adc_start, sync_ready, sync_late;
  logic       conv_done, cs_req, relay_busy, ss_busy;
  logic [1:0] adc_res;

  int errs = 0;
  int checks = 0;

  adcseq_top #(.AW(6), .XB(3), .RW(2), .FAST_ADC(1), .RLY_SD(RSD), .BSW_CYC(BSW),
               .RLY_ED(RED), .SS_SD(SSD), .SS_ED(SED), .SYNC_TO(STO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_init(cmd_init),
    .cmd_addr(cmd_addr), .cmd_relay(cmd_relay), .cmd_xsync(cmd_xsync),
    .cmd_read(cmd_read), .sense_rst(sense_rst), .res_wr(res_wr), .res_val(res_val),
    .adc_eoc(adc_eoc), .sync_start(sync_start), .pt_addr(pt_addr),
    .addr_busy(addr_busy), .x_drv(x_drv), .y_drv(y_drv), .relay_drv(relay_drv),
    .ss_drv(ss_drv), .adc_start(adc_start), .sync_ready(sync_ready),
    .sync_late(sync_late), .conv_done(conv_done), .cs_req(cs_req),
    .relay_busy(relay_busy), .ss_busy(ss_busy), .adc_res(adc_res)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_x(input logic [5:0] a);
    return 8'(1) << a[2:0];
  endfunction
  function automatic logic [7:0] exp_y(input logic [5:0] a);
    return 8'(1) << a[5:3];
  endfunction
  function automatic int exp_start_gap(input bit rly);
    return rly ? (RSD + BSW) : SSD;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_read();
    cmd_read = 1'b1; @(negedge clk); cmd_read = 1'b0;
  endtask

  task automatic pulse_sense();
    sense_rst = 1'b1; @(negedge clk); sense_rst = 1'b0;
  endtask

  task automatic run_op(input logic [5:0] a, input bit rly, input bit xs, input bit ch,
                        input int w, input int g);
    int n;
    logic [1:0] r0;
    @(negedge clk);
    cmd_addr = a; cmd_relay = rly; cmd_xsync = xs;
    if (ch) cmd_init = 1'b1; else cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_init = 1'b0;
    chk("R2 addr_busy", addr_busy, 1);
    chk("R2 pt_addr", pt_addr, a);
    chk("R11 late cleared", sync_late, 0);
    n = 0;
    while (!(relay_drv || ss_drv) && n < 100) begin @(negedge clk); n++; end
    chk("R3 load latency", n, 3);
    chk("R3 x_drv", x_drv, exp_x(a));
    chk("R3 y_drv", y_drv, exp_y(a));
    chk("R3 busy cleared", addr_busy, 0);
    chk("R3 increment", pt_addr, 6'(a + 6'd1));
    chk("R3 driver kind", {relay_drv, ss_drv}, rly ? 2 : 1);
    cmd_wr = 1'b1; cmd_addr = ~a;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R8 running drop busy", addr_busy, 0);
    chk("R8 running drop addr", pt_addr, 6'(a + 6'd1));
    n = 1;
    while (!(adc_start || sync_ready) && n < 1000) begin @(negedge clk); n++; end
    chk(xs && rly ? "R10 ready delay" : "R4 start delay", n, exp_start_gap(rly));
    if (rly && xs) begin
      chk("R10 no start before sync", adc_start, 0);
      repeat (w) @(negedge clk);
      sync_start = 1'b1;
      @(negedge clk);
      sync_start = 1'b0;
      chk("R10 start after sync", adc_start, 1);
      chk("R11 late flag", sync_late, (w >= STO) ? 1 : 0);
    end
    if (rly) chk("R5 relay held at start", relay_drv, 1);
    else     chk("R5 ss reset at start", ss_drv, 0);
    r0 = adc_res;
    if (rly) begin
      res_wr = 1'b1; res_val = ~r0;
      @(negedge clk);
      res_wr = 1'b0;
      chk("R12 res blocked", adc_res, r0);
    end else begin
      @(negedge clk);
    end
    chk("R4 single pulse", adc_start, 0);
    repeat (g) @(negedge clk);
    adc_eoc = 1'b1;
    @(negedge clk);
    adc_eoc = 1'b0;
    chk("R5 drivers off after eoc", relay_drv | ss_drv, 0);
    if (rly) begin
      repeat (RED - 1) @(negedge clk);
      chk("R6 end delay hold", conv_done | cs_req, 0);
      @(negedge clk);
    end
    chk("R7 conv_done", conv_done, ch ? 0 : 1);
    chk("R7 cs_req", cs_req, ch ? 1 : 0);
  endtask

  task automatic finish_op(input bit ch, input bit rly, input bit probe);
    logic [5:0] a0;
    a0 = pt_addr;
    if (probe && ch) begin
      cmd_wr = 1'b1; cmd_addr = 6'd5; cmd_relay = 1'b0;
      @(negedge clk); cmd_wr = 1'b0;
      chk("R8 write dropped on cs_req", addr_busy, 0);
      chk("R8 write dropped addr", pt_addr, a0);
    end
    pulse_sense();
    chk("R7 cleared done", conv_done, 0);
    chk("R7 cleared cs", cs_req, 0);
    if (!ch) begin
      chk("R9 relay_busy held", relay_busy, rly ? 1 : 0);
      chk("R9 ss_busy held", ss_busy, rly ? 0 : 1);
      if (probe && !rly) begin
        cmd_wr = 1'b1; cmd_addr = 6'd9; cmd_relay = 1'b1;
        @(negedge clk); cmd_wr = 1'b0;
        chk("R8 write dropped on ss_busy", addr_busy, 0);
        cmd_init = 1'b1;
        @(negedge clk); cmd_init = 1'b0;
        chk("R8 init dropped on ss_busy", addr_busy, 0);
        chk("R8 addr unchanged", pt_addr, a0);
      end
      pulse_read();
      chk("R9 busy cleared", relay_busy | ss_busy, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    bit rly, xs, ch;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    cmd_wr = 0; cmd_init = 0; cmd_addr = 0; cmd_relay = 0; cmd_xsync = 0;
    cmd_read = 0; sense_rst = 0; res_wr = 0; res_val = 0; adc_eoc = 0; sync_start = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset drivers", {x_drv, y_drv, relay_drv, ss_drv}, 0);
    chk("R1 reset flags", {addr_busy, adc_start, sync_ready, sync_late, conv_done,
                           cs_req, relay_busy, ss_busy}, 0);
    chk("R1 reset res", adc_res, 0);
    rst_n = 1'b1;
    @(negedge clk);
    res_wr = 1'b1; res_val = 2'd2;
    @(negedge clk);
    res_wr = 1'b0;
    chk("R12 res idle write", adc_res, 2);

    run_op(6'd42, 1'b0, 1'b0, 1'b0, 0, 2);   finish_op(1'b0, 1'b0, 1'b1);
    run_op(6'd17, 1'b1, 1'b0, 1'b1, 0, 3);   finish_op(1'b1, 1'b1, 1'b1);
    run_op(6'd63, 1'b0, 1'b0, 1'b1, 0, 1);   finish_op(1'b1, 1'b0, 1'b0);
    run_op(6'd8,  1'b1, 1'b1, 1'b0, 3, 2);   finish_op(1'b0, 1'b1, 1'b0);
    run_op(6'd33, 1'b1, 1'b1, 1'b0, STO + 5, 1); finish_op(1'b0, 1'b1, 1'b0);
    run_op(6'd0,  1'b1, 1'b0, 1'b0, 0, 4);   finish_op(1'b0, 1'b1, 1'b0);

    for (int k = 0; k < 8; k++) begin
      rly = 1'($urandom);
      xs  = rly && 1'($urandom);
      ch  = 1'($urandom);
      run_op(6'($urandom), rly, xs, ch, int'($urandom % 10), 1 + int'($urandom % 5));
      finish_op(ch, rly, 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule